// File: doc/BRIEF.md
# Interrupt Pin Edge Detect and Message Builder

This block watches a group of interrupt input pins and turns each assertion of a pin into one outgoing interrupt message. Every pin has one stored level bit. A pin fires only when it is seen high while its stored bit is low. A pin that stays high never fires again, and a falling pin only clears its stored bit. Each pin has a routing entry, supplied as a flat vector on `tbl_i`. A pin whose entry has its mask bit set at the moment it rises is dropped. An unmasked rise is held pending until the message engine can serve it.

The engine serves pending pins one at a time, lowest pin number first. It copies the routing fields into a message and presents that message on a valid/ready output. When the entry selects the external-vector delivery mode, the engine first asks an attached legacy controller for the vector over a req/ack pair, and it sends the message only after the answer arrives. Destination lookup, bus delivery and any fairer arbitration are left to the logic that consumes the message.

Top module: `irq_msg_builder`

## Requirements
- R1: After reset every stored pin level is low, nothing is pending, `msg_valid_o` is 0 and `ext_req_o` is 0. A pin already high when reset is released therefore counts as a rise.
- R2: A pin seen high while its stored level is low yields exactly one message. While the pin stays high, no further message comes from it.
- R3: Lowering a pin only clears its stored level and yields no message. A later rise of the same pin yields a message again.
- R4: Routing entry bit 14 is the mask. When it is 1 at the cycle the pin rises, that rise yields no message.
- R5: Routing entry layout (W = 23 bits per pin, pin k at `tbl_i[k*23 +: 23]`): [7:0] vector, [10:8] delivery mode, [11] destination mode, [12] polarity, [13] trigger, [22:15] destination. The message copies destination, delivery mode and destination mode from the entry. Its level is the polarity bit and its trigger is the trigger bit.
- R6: For every delivery mode other than 3'b111, the message vector is entry bits [7:0]. For mode 3'b111, the block raises `ext_req_o` and keeps `msg_valid_o` low until a cycle with `ext_ack_i` high. It then sends a message whose vector is `ext_vec_i` as sampled in that cycle.
- R7: When several pins are pending, the lowest-numbered one is served first. The others stay pending and are served afterwards, in order.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the message holds all of its fields. Each valid-and-ready cycle consumes exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Interrupt input levels |
| tbl_i | input | NUM_PINS*23 | Routing entries, one 23-bit entry per pin |
| ext_req_o | output | 1 | Request to the legacy controller for a vector |
| ext_ack_i | input | 1 | Legacy controller answer strobe |
| ext_vec_i | input | 8 | Vector from the legacy controller |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_dest_o | output | 8 | Message destination |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_dest_mode_o | output | 1 | Message destination mode |
| msg_level_o | output | 1 | Message level (entry polarity) |
| msg_trigger_o | output | 1 | Message trigger (entry trigger bit) |

## Verification
The bench holds a pin high for many cycles after its message has been served. A design that fires on level rather than on a stored-state change would send a second message. It also lowers a pin and waits, to catch a design that emits on the falling side, then raises the pin again to catch one that never clears the stored bit. Two pins rising in the same cycle with the consumer stalled expose a wrong service order and a message that changes while it waits for ready. An external-vector entry with a slow acknowledge catches a design that sends early or takes the vector from the table. A pin held high through reset catches a stored level that does not reset low.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DM_W   = 3;

  localparam logic [DM_W-1:0] DM_EXT_VECTOR = 3'b111;

  // Routing entry, MSB first: dest, mask, trigger, polarity, dest mode, delivery mode, vector
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              dst_mode;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vector;
  } route_t;

  localparam int ENTRY_W = $bits(route_t);

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [DM_W-1:0]   dmode;
    logic              dst_mode;
    logic              level;
    logic              trig;
    logic [VEC_W-1:0]  vector;
  } imsg_t;

  localparam int MSG_W = $bits(imsg_t);

  function automatic logic wants_ext_vector(input route_t e);
    return e.dmode == DM_EXT_VECTOR;
  endfunction

  function automatic imsg_t compose_msg(input route_t e, input logic [VEC_W-1:0] vec);
    imsg_t m;
    m.dest     = e.dest;
    m.dmode    = e.dmode;
    m.dst_mode = e.dst_mode;
    m.level    = e.pol;
    m.trig     = e.trig;
    m.vector   = vec;
    return m;
  endfunction

endpackage

// File: rtl/pin_edge_tracker.sv
module pin_edge_tracker #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] level_q_o,
  output logic [NUM_PINS-1:0] rise_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic lvl_q;

    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= pin_i[g];
    end

    assign level_q_o[g] = lvl_q;
    assign rise_o[g]    = pin_i[g] & ~lvl_q;
  end

endmodule

// File: rtl/pend_arbiter.sv
module pend_arbiter #(
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic                take_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] grant_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                any_o
);

  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] clear_w;

  // lowest set bit of the pending vector
  assign grant_o = pend_q & (~pend_q + {{(NUM_PINS-1){1'b0}}, 1'b1});
  assign any_o   = |pend_q;
  assign clear_w = take_i ? grant_o : '0;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pend_q[i]) idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clear_w) | set_i;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/msg_engine.sv
module msg_engine
  import irq_msg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        any_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [NUM_PINS*ENTRY_W-1:0] tbl_i,
  output logic                        take_o,
  output logic                        ext_req_o,
  input  logic                        ext_ack_i,
  input  logic [VEC_W-1:0]            ext_vec_i,
  output logic                        msg_valid_o,
  input  logic                        msg_ready_i,
  output imsg_t                       msg_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} eng_st_t;

  eng_st_t state_q;
  route_t  entry_q;
  imsg_t   msg_q;
  route_t  sel_entry;

  assign sel_entry = route_t'(tbl_i[int'(idx_i)*ENTRY_W +: ENTRY_W]);
  assign take_o    = (state_q == ST_IDLE) && any_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= '0;
      msg_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (any_i) begin
            entry_q <= sel_entry;
            if (wants_ext_vector(sel_entry)) begin
              state_q <= ST_FETCH;
            end else begin
              msg_q   <= compose_msg(sel_entry, sel_entry.vector);
              state_q <= ST_SEND;
            end
          end
        end
        ST_FETCH: begin
          if (ext_ack_i) begin
            msg_q   <= compose_msg(entry_q, ext_vec_i);
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (msg_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ext_req_o   = (state_q == ST_FETCH);
  assign msg_valid_o = (state_q == ST_SEND);
  assign msg_o       = msg_q;

endmodule

// File: rtl/irq_msg_builder.sv
module irq_msg_builder
  import irq_msg_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pin_i,
  input  logic [NUM_PINS*ENTRY_W-1:0] tbl_i,
  output logic                        ext_req_o,
  input  logic                        ext_ack_i,
  input  logic [VEC_W-1:0]            ext_vec_i,
  output logic                        msg_valid_o,
  input  logic                        msg_ready_i,
  output logic [DEST_W-1:0]           msg_dest_o,
  output logic [VEC_W-1:0]            msg_vector_o,
  output logic [DM_W-1:0]             msg_dmode_o,
  output logic                        msg_dest_mode_o,
  output logic                        msg_level_o,
  output logic                        msg_trigger_o
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] level_q_w;
  logic [NUM_PINS-1:0] rise_w;
  logic [NUM_PINS-1:0] mask_w;
  logic [NUM_PINS-1:0] accept_w;
  logic [NUM_PINS-1:0] pend_w;
  logic [NUM_PINS-1:0] grant_w;
  logic [IDX_W-1:0]    idx_w;
  logic                any_w;
  logic                take_w;
  imsg_t               msg_w;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_mask
    route_t ent;
    assign ent       = route_t'(tbl_i[g*ENTRY_W +: ENTRY_W]);
    assign mask_w[g] = ent.mask;
  end

  assign accept_w = rise_w & ~mask_w;

  pin_edge_tracker #(.NUM_PINS(NUM_PINS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .level_q_o(level_q_w),
    .rise_o   (rise_w)
  );

  pend_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (accept_w),
    .take_i (take_w),
    .pend_o (pend_w),
    .grant_o(grant_w),
    .idx_o  (idx_w),
    .any_o  (any_w)
  );

  msg_engine #(.NUM_PINS(NUM_PINS)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_i      (any_w),
    .idx_i      (idx_w),
    .tbl_i      (tbl_i),
    .take_o     (take_w),
    .ext_req_o  (ext_req_o),
    .ext_ack_i  (ext_ack_i),
    .ext_vec_i  (ext_vec_i),
    .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i),
    .msg_o      (msg_w)
  );

  assign msg_dest_o      = msg_w.dest;
  assign msg_vector_o    = msg_w.vector;
  assign msg_dmode_o     = msg_w.dmode;
  assign msg_dest_mode_o = msg_w.dst_mode;
  assign msg_level_o     = msg_w.level;
  assign msg_trigger_o   = msg_w.trig;

endmodule

// File: rtl/irq_msg_builder_chk.sv
module irq_msg_builder_chk
  import irq_msg_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] level_q,
  input logic [NUM_PINS-1:0] mask_v,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] grant,
  input logic                ext_req,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [MSG_W-1:0]    msg_bits
);

  // R8: a stalled message keeps every field
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_bits));

  // R6: no message is offered while the external vector is outstanding
  assert_fetch_blocks_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !msg_valid);

  // R7: at most one pin is granted, and it is a pending one
  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~pend) == '0));

  // R7: nothing below the granted pin is pending
  assert_grant_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant - 1'b1) & pend) == '0));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
    // R2 R3 R4: a pin becomes pending only from an unmasked rise over a low stored level
    assert_pend_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(pin_i[g]) && !$past(level_q[g]) && !$past(mask_v[g]));
  end

endmodule

bind irq_msg_builder irq_msg_builder_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_i    (pin_i),
  .level_q  (level_q_w),
  .mask_v   (mask_w),
  .pend     (pend_w),
  .grant    (grant_w),
  .ext_req  (ext_req_o),
  .msg_valid(msg_valid_o),
  .msg_ready(msg_ready_i),
  .msg_bits (msg_w)
);

// File: tb/irq_msg_builder_bench.sv
`timescale 1ns/1ps
module irq_msg_builder_bench;

  localparam int NP = 8;
  localparam int EW = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     pin = '0;
  logic [NP*EW-1:0]  tbl;
  logic              ext_req;
  logic              ext_ack = 1'b0;
  logic [7:0]        ext_vec = '0;
  logic              mvalid;
  logic              mready = 1'b0;
  logic [7:0]        mdest, mvec;
  logic [2:0]        mdmode;
  logic              mdm, mlvl, mtrig;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_msg_builder #(.NUM_PINS(NP)) u_irq_msg_builder (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .tbl_i(tbl),
    .ext_req_o(ext_req), .ext_ack_i(ext_ack), .ext_vec_i(ext_vec),
    .msg_valid_o(mvalid), .msg_ready_i(mready),
    .msg_dest_o(mdest), .msg_vector_o(mvec), .msg_dmode_o(mdmode),
    .msg_dest_mode_o(mdm), .msg_level_o(mlvl), .msg_trigger_o(mtrig)
  );

  // entry = {dest[22:15], mask[14], trig[13], pol[12], dmode_dst[11], dmode[10:8], vec[7:0]}
  function automatic logic [22:0] ent(input logic [7:0] d, input logic m, input logic t,
                                      input logic p, input logic dm, input logic [2:0] mode,
                                      input logic [7:0] v);
    return {d, m, t, p, dm, mode, v};
  endfunction

  // expected message {dest, dmode, dst_mode, level, trigger, vector} per R5/R6
  function automatic logic [21:0] expect_msg(input logic [22:0] e, input logic [7:0] v);
    return {e[22:15], e[10:8], e[11], e[12], e[13], v};
  endfunction

  function automatic logic [21:0] seen_msg();
    return {mdest, mdmode, mdm, mlvl, mtrig, mvec};
  endfunction

  // {pin[2:0], entry[22:0]}
  localparam logic [25:0] VECS [6] = '{
    {3'd0, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h31},
    {3'd1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 3'b001, 8'h42},
    {3'd3, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h77},
    {3'd4, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100, 8'hA5},
    {3'd6, 8'h7E, 1'b0, 1'b0, 1'b1, 1'b1, 3'b010, 8'hC3},
    {3'd7, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 3'b101, 8'hEE}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ent(input int p, input logic [22:0] e);
    tbl[p*EW +: EW] = e;
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (mvalid) got = 1;
    end
  endtask

  task automatic take_msg();
    mready = 1'b1;
    @(negedge clk);
    mready = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mvalid) seen = 1;
    end
    check(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit got;
    logic [22:0] e;
    for (int p = 0; p < NP; p++) tbl[p*EW +: EW] = ent(8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h0);

    // R1: pin 0 high through reset with an unmasked entry
    set_ent(0, ent(8'h05, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h11));
    pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    check(mvalid == 1'b0, "R1 valid in reset", {31'd0, mvalid}, 32'd0);
    check(ext_req == 1'b0, "R1 req in reset", {31'd0, ext_req}, 32'd0);
    rst_n = 1'b1;
    wait_valid(8, got);
    e = ent(8'h05, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h11);
    check(got && seen_msg() == expect_msg(e, 8'h11), "R1 high-at-release fires",
          {10'd0, seen_msg()}, {10'd0, expect_msg(e, 8'h11)});
    if (got) take_msg();
    pin[0] = 1'b0;
    set_ent(0, ent(8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h0));
    repeat (3) @(negedge clk);

    // R4 R5: vector table walk
    for (int k = 0; k < 6; k++) begin
      int p;
      p = int'(VECS[k][25:23]);
      e = VECS[k][22:0];
      set_ent(p, e);
      @(negedge clk);
      pin[p] = 1'b1;
      if (e[14]) begin
        expect_quiet(8, "R4 masked rise");
      end else begin
        wait_valid(8, got);
        check(got && seen_msg() == expect_msg(e, e[7:0]), "R5 fields",
              {10'd0, seen_msg()}, {10'd0, expect_msg(e, e[7:0])});
        if (got) take_msg();
      end
      pin[p] = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R2: held high fires once; R3: fall is silent, next rise fires again
    e = ent(8'h22, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 8'h6B);
    set_ent(2, e);
    pin[2] = 1'b1;
    wait_valid(8, got);
    check(got && mvec == 8'h6B, "R2 first rise", {24'd0, mvec}, 32'h6B);
    if (got) take_msg();
    expect_quiet(12, "R2 held high no refire");
    pin[2] = 1'b0;
    expect_quiet(12, "R3 fall silent");
    pin[2] = 1'b1;
    wait_valid(8, got);
    check(got && mvec == 8'h6B, "R3 rise after fall", {24'd0, mvec}, 32'h6B);
    if (got) take_msg();
    pin[2] = 1'b0;
    repeat (2) @(negedge clk);

    // R6: external vector path
    e = ent(8'h44, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 8'h99);
    set_ent(5, e);
    pin[5] = 1'b1;
    got = 0;
    for (int i = 0; i < 8 && !got; i++) begin
      @(negedge clk);
      if (ext_req) got = 1;
    end
    check(got && !mvalid, "R6 request raised, no message", {30'd0, got, mvalid}, 32'h2);
    expect_quiet(4, "R6 no message before ack");
    ext_vec = 8'h5A;
    ext_ack = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0;
    ext_vec = 8'h00;
    check(mvalid && seen_msg() == expect_msg(e, 8'h5A), "R6 vector from controller",
          {10'd0, seen_msg()}, {10'd0, expect_msg(e, 8'h5A)});
    if (mvalid) take_msg();
    pin[5] = 1'b0;
    repeat (2) @(negedge clk);

    // R7 R8: two pins at once, consumer stalled
    set_ent(3, ent(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h33));
    set_ent(6, ent(8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h66));
    pin[3] = 1'b1;
    pin[6] = 1'b1;
    wait_valid(8, got);
    check(got && mvec == 8'h33, "R7 lowest pin first", {24'd0, mvec}, 32'h33);
    repeat (4) @(negedge clk);
    check(mvalid && mvec == 8'h33 && mdest == 8'h01, "R8 held while stalled",
          {16'd0, mdest, mvec}, {16'd0, 8'h01, 8'h33});
    take_msg();
    check(!mvalid, "R8 one message per handshake", {31'd0, mvalid}, 32'd0);
    wait_valid(8, got);
    check(got && mvec == 8'h66, "R7 other pin served next", {24'd0, mvec}, 32'h66);
    if (got) take_msg();
    expect_quiet(6, "R7 nothing left pending");
    pin = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule